// File: doc/BRIEF.md
# SDRAM Command Legality Tracker

This block sits beside the command pins of a single-data-rate SDRAM. It can sit on the controller side or on a bus monitor. On every clock it turns chip select, the row and column strobes, write enable, clock enable and address bit 10 into one command code. From that code it follows the state the device must be in. It raises a flag whenever the command is not allowed in that state.

The tracker follows seven states: idle, precharging, bank active, auto-refresh, self-refresh, power-down and mode-register setup. Precharging, auto-refresh and mode-register setup are timed states. Each one returns to idle after a number of clock cycles set by a parameter: `T_RP`, `T_RFC` and `T_MRD`. Bank active has no internal row or burst model. It waits for a precharge. The state, the decoded command and the error flag are all registered, so they appear together one clock after the command is sampled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: The command code is decoded as follows. With `cke` low, the pattern cs_n=0, ras_n=0, cas_n=0, we_n=1 gives SELF (9), and every other pattern gives PDEN (11). With `cke` high and `cs_n` high the code is DESL (0). Otherwise {ras_n,cas_n,we_n} selects the code: 111 NOP (1), 110 BST (2), 101 READ (3), 100 WRITE (4), 011 ACT (5), 010 PRE (6) or, with `a10` high, PALL (7), 001 REF (8), 000 MRS (10). `cmd` shows the code one clock after it is sampled.
- R2: A synchronous reset sets `state` to idle, `cmd` to DESL and `illegal` to 0. The state codes are: idle 0, precharging 1, active 2, refresh 3, self-refresh 4, power-down 5, mode setup 6.
- R3: PRE or PALL in the active state puts the tracker in precharging. It stays there for exactly `T_RP` clocks and then goes to idle.
- R4: In precharging, DESL, NOP, BST, PRE and PALL are accepted. A further PRE or PALL does not restart the timer. Every other code raises `illegal`.
- R5: In idle, DESL, NOP, BST, PRE and PALL leave the state unchanged without an error. READ and WRITE raise `illegal`.
- R6: In idle, ACT goes to active, REF goes to refresh and MRS goes to mode setup.
- R7: SELF in idle goes to self-refresh. The state holds while `cke` stays low. The first clock with `cke` high returns it to idle.
- R8: PDEN in idle goes to power-down. The state holds while `cke` stays low. The first clock with `cke` high returns it to idle.
- R9: Refresh lasts `T_RFC` clocks and mode setup lasts `T_MRD` clocks, and each then returns to idle. Only DESL and NOP are legal in these two states.
- R10: `illegal` is high for the single clock that shows the offending command on `cmd`. In an untimed state, an illegal command leaves the state unchanged.
- R11: In active, DESL, NOP, BST, READ and WRITE are accepted and the state stays active. ACT, REF, SELF, MRS and PDEN raise `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit 10; selects precharge-all |
| state | output | 3 | Tracked device state |
| cmd | output | 4 | Registered command code |
| illegal | output | 1 | Command was illegal in the state it met |

## Verification
The assertions assume that every command pin is 0 or 1 at each clock edge. They also assume that reset is held across at least one edge before checking starts. Their `$past` terms compare the registered command with the state it was applied to. The stimulus never drives unknown values and releases reset only after two edges. Its directed part walks every state through each of its legal and illegal commands. A random part then drives free pin patterns, with clock enable held low only rarely, so that the tracker still leaves the low-power states and visits the timed ones.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int T_RP  = 3,
  parameter int T_RFC = 6,
  parameter int T_MRD = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       a10,
  output logic [2:0] state,
  output logic [3:0] cmd,
  output logic       illegal
);
  localparam int MAX_AB = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAXT   = (T_RFC > MAX_AB) ? T_RFC : MAX_AB;
  localparam int CW     = $clog2(MAXT + 1);

  localparam logic [3:0] C_DESL = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_READ = 4'd3,
                         C_WRITE = 4'd4, C_ACT = 4'd5, C_PRE = 4'd6, C_PALL = 4'd7,
                         C_REF = 4'd8, C_SELF = 4'd9, C_MRS = 4'd10, C_PDEN = 4'd11;
  localparam logic [2:0] S_IDLE = 3'd0, S_PRE = 3'd1, S_ACT = 3'd2, S_REF = 3'd3,
                         S_SELF = 3'd4, S_PDN = 3'd5, S_MRS = 3'd6;

  logic [2:0]    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    cmd_d, cmd_q;
  logic          bad, err_q;
  logic          is_idle_nop, is_quiet;

  always_comb begin
    if (!cke)
      cmd_d = (!cs_n && !ras_n && !cas_n && we_n) ? C_SELF : C_PDEN;
    else if (cs_n)
      cmd_d = C_DESL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd_d = C_NOP;
        3'b110:  cmd_d = C_BST;
        3'b101:  cmd_d = C_READ;
        3'b100:  cmd_d = C_WRITE;
        3'b011:  cmd_d = C_ACT;
        3'b010:  cmd_d = a10 ? C_PALL : C_PRE;
        3'b001:  cmd_d = C_REF;
        default: cmd_d = C_MRS;
      endcase
    end
  end

  assign is_quiet    = (cmd_d == C_DESL) || (cmd_d == C_NOP);
  assign is_idle_nop = is_quiet || (cmd_d == C_BST) || (cmd_d == C_PRE) || (cmd_d == C_PALL);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bad   = 1'b0;
    case (st_q)
      S_IDLE: begin
        case (cmd_d)
          C_READ, C_WRITE: bad = 1'b1;
          C_ACT:  st_d = S_ACT;
          C_REF:  begin st_d = S_REF; cnt_d = CW'(T_RFC - 1); end
          C_MRS:  begin st_d = S_MRS; cnt_d = CW'(T_MRD - 1); end
          C_SELF: st_d = S_SELF;
          C_PDEN: st_d = S_PDN;
          default: ;
        endcase
      end
      S_PRE, S_REF, S_MRS: begin
        bad = (st_q == S_PRE) ? !is_idle_nop : !is_quiet;
        if (cnt_q == '0) st_d = S_IDLE;
        else             cnt_d = cnt_q - CW'(1);
      end
      S_ACT: begin
        case (cmd_d)
          C_PRE, C_PALL: begin st_d = S_PRE; cnt_d = CW'(T_RP - 1); end
          C_DESL, C_NOP, C_BST, C_READ, C_WRITE: ;
          default: bad = 1'b1;
        endcase
      end
      S_SELF, S_PDN: if (cke) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      cmd_q <= C_DESL;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cmd_q <= cmd_d;
      err_q <= bad;
    end
  end

  assign state   = st_q;
  assign cmd     = cmd_q;
  assign illegal = err_q;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int T_RP = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic [2:0] state,
  input logic [3:0] cmd,
  input logic       illegal
);
  int run;

  always_ff @(posedge clk) begin
    if (rst)                run <= 0;
    else if (state == 3'd1) run <= run + 1;
    else                    run <= 0;
  end

  a_r3_prech_bound: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd1) |-> (run < T_RP));
  a_r3_prech_full: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd0 && run != 0) |-> (run == T_RP));
  a_r4_act_in_prech: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == 3'd1 && cmd == 4'd5) |-> illegal);
  a_r5_rw_in_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == 3'd0 && (cmd == 4'd3 || cmd == 4'd4)) |-> illegal);
  a_r7_self_hold: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd4 && !cke) |=> (state == 3'd4));
  a_r8_pdn_exit: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd5 && cke) |=> (state == 3'd0));
  a_r10_state_kept: assert property (@(posedge clk) disable iff (rst)
    (illegal && ($past(state) == 3'd0 || $past(state) == 3'd2)) |-> (state == $past(state)));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.T_RP(T_RP)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .state(state), .cmd(cmd), .illegal(illegal)
);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  localparam int TRP = 3, TRFC = 6, TMRD = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [2:0] state;
  logic [3:0] cmd;
  logic illegal;
  int checks = 0, errors = 0;
  int m_st = 0, m_left = 0, m_cmd = 0, m_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_cmd_tracker #(.T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) i_sdram_cmd_tracker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .a10(a10), .state(state), .cmd(cmd), .illegal(illegal));

  function automatic int decode(bit k, bit c, bit r, bit s, bit w, bit a);
    int p = r * 4 + s * 2 + w;
    if (!k) return (!c && p == 1) ? 9 : 11;
    if (c) return 0;
    case (p)
      7: return 1; 6: return 2; 5: return 3; 4: return 4;
      3: return 5; 2: return a ? 7 : 6; 1: return 8; default: return 10;
    endcase
  endfunction

  task automatic model_step();
    int c = decode(cke, cs_n, ras_n, cas_n, we_n, a10);
    m_cmd = c;
    m_err = 0;
    if (m_st == 0) begin
      if (c == 3 || c == 4) m_err = 1;
      else if (c == 5) m_st = 2;
      else if (c == 8) begin m_st = 3; m_left = TRFC; end
      else if (c == 10) begin m_st = 6; m_left = TMRD; end
      else if (c == 9) m_st = 4;
      else if (c == 11) m_st = 5;
    end else if (m_st == 1 || m_st == 3 || m_st == 6) begin
      if (m_st == 1) m_err = (c > 2 && c != 6 && c != 7) ? 1 : 0;
      else m_err = (c > 1) ? 1 : 0;
      m_left--;
      if (m_left == 0) m_st = 0;
    end else if (m_st == 2) begin
      if (c == 6 || c == 7) begin m_st = 1; m_left = TRP; end
      else if (c > 4) m_err = 1;
    end else if (cke) m_st = 0;
  endtask

  task automatic compare(string tag);
    checks++;
    if (state !== 3'(m_st) || cmd !== 4'(m_cmd) || illegal !== 1'(m_err)) begin
      errors++;
      $display("FAIL %s: state/cmd/illegal = %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, state, cmd, illegal, m_st, m_cmd, m_err);
    end
  endtask

  task automatic drive(bit k, bit c, bit r, bit s, bit w, bit a, string tag);
    cke = k; cs_n = c; ras_n = r; cas_n = s; we_n = w; a10 = a;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic op(string name, string tag, bit k = 1);
    case (name)
      "DESL":  drive(k, 1, 1, 1, 1, 0, tag);
      "NOP":   drive(k, 0, 1, 1, 1, 0, tag);
      "BST":   drive(k, 0, 1, 1, 0, 0, tag);
      "READ":  drive(k, 0, 1, 0, 1, 0, tag);
      "WRITE": drive(k, 0, 1, 0, 0, 0, tag);
      "ACT":   drive(k, 0, 0, 1, 1, 0, tag);
      "PRE":   drive(k, 0, 0, 1, 0, 0, tag);
      "PALL":  drive(k, 0, 0, 1, 0, 1, tag);
      "REF":   drive(k, 0, 0, 0, 1, 0, tag);
      default: drive(k, 0, 0, 0, 0, 0, tag);
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare("R2");
    rst = 1'b0;
    // R5 idle no-ops and illegal read/write
    op("NOP", "R5"); op("DESL", "R5"); op("BST", "R5"); op("PRE", "R5"); op("PALL", "R5");
    op("READ", "R5"); op("WRITE", "R5");
    op("NOP", "R10");
    // R6 / R11 active
    op("ACT", "R6"); op("READ", "R11"); op("WRITE", "R11"); op("BST", "R11");
    op("ACT", "R11"); op("REF", "R11"); op("MRS", "R11"); op("NOP", "R11", 0);
    op("NOP", "R10");
    // R3 / R4 precharge
    op("PRE", "R3"); op("READ", "R4"); op("PALL", "R4"); op("NOP", "R3"); op("NOP", "R3");
    op("ACT", "R6"); op("PALL", "R3"); op("ACT", "R4"); op("REF", "R4"); op("MRS", "R4");
    op("NOP", "R3");
    // R9 refresh and mode setup
    op("REF", "R6"); op("MRS", "R9"); op("BST", "R9");
    for (int i = 0; i < TRFC; i++) op("NOP", "R9");
    op("MRS", "R6"); op("ACT", "R9"); op("DESL", "R9"); op("NOP", "R9");
    // R7 self-refresh
    op("REF", "R7", 0);
    for (int i = 0; i < 4; i++) op("NOP", "R7", 0);
    op("NOP", "R7"); op("NOP", "R7");
    // R8 power-down
    op("DESL", "R8", 0);
    for (int i = 0; i < 3; i++) op("DESL", "R8", 0);
    op("DESL", "R8"); op("NOP", "R8");
    // R1 random patterns
    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom_range(0, 99);
      bit k = (pick < 8) ? 1'b0 : 1'b1;
      drive(k, ($urandom_range(0, 4) == 0), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), "R1");
    end
    rst = 1'b1;
    m_st = 0; m_left = 0; m_cmd = 0; m_err = 0;
    @(posedge clk);
    @(negedge clk);
    compare("R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule